// File: doc/BRIEF.md
# Counter-addressed observation point multiplexer

This block brings a set of internal monitor points out through a single shared output pin. In normal operation the pin carries the functional signal. When test mode is on, the pin carries one monitor point, chosen by an address counter inside the block. The tester therefore needs only two added connections: the test-mode enable and the counter clock. It does not need a set of address pins.

The address starts at point 0 after a synchronous reset. It then moves to the next point on every clock edge while test mode is on, and wraps around at the end of the set. A tester that counts its own clock edges always knows which point it is looking at.

A parameter selects how the address is held. The first choice is a binary counter with a decoder. The second is a one-hot ring shift register. Both choices select the points in the same order.

Top module: `mon_tap`

## Requirements
- R1: The block has 2^ADDR_W monitor points (8 with the default ADDR_W=3). In test mode (test_en=1), pin_out equals mon_pts[k], where k is the current point index.
- R2: srst is synchronous and active high. A rising clock edge with srst=1 sets the index to 0, whatever the value of test_en.
- R3: A rising clock edge with srst=0 and test_en=1 raises the index by one.
- R4: After point 2^ADDR_W-1, the next advancing edge selects point 0 again. After k advancing edges from reset, the index is k mod 2^ADDR_W.
- R5: In normal mode (test_en=0), pin_out equals func_out, and mon_pts has no effect on pin_out.
- R6: While test_en=0 the index is held. When test mode resumes, the same point as before appears on pin_out.
- R7: Exactly one monitor point is selected at any time after reset.
- R8: Changing any monitor point other than the selected one does not change pin_out.
- R9: The binary-counter variant (STYLE=SEL_BINARY) and the ring-register variant (STYLE=SEL_RING) produce the same pin_out sequence for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock that steps the point address |
| srst | input | 1 | Synchronous, active-high reset of the address to point 0 |
| test_en | input | 1 | 1 = test mode (observe a point), 0 = normal mode |
| func_out | input | 1 | Functional signal shown on the pin in normal mode |
| mon_pts | input | 2^ADDR_W | Internal monitor points |
| pin_out | output | 1 | Shared output pin |

## Verification
The assertions check on every cycle that:
- the selection is one-hot;
- a reset edge lands on point 0;
- each test-mode edge rotates the selection by one position;
- the selection holds still in normal mode;
- the pin follows the functional signal in normal mode.

Only the bench scenarios can show the following:
- the index seen at the pin is the tester's own count, modulo the number of points, across a full wrap;
- the same point reappears after a normal-mode pause;
- toggling the unselected points leaves the pin untouched;
- the two address variants give identical sequences.

// File: rtl/mon_tap_pkg.sv
package mon_tap_pkg;
    typedef enum logic {
        SEL_BINARY = 1'b0,
        SEL_RING   = 1'b1
    } sel_style_e;
endpackage

// File: rtl/mon_tap_ctr.sv
module mon_tap_ctr
    import mon_tap_pkg::*;
#(
    parameter int         NPTS  = 8,
    parameter sel_style_e STYLE = SEL_BINARY
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            adv,
    output logic [NPTS-1:0] sel
);
    localparam int AW = $clog2(NPTS);

    generate
        if (STYLE == SEL_BINARY) begin : g_bin
            typedef struct packed {
                logic [AW-1:0] addr;
            } bin_st_t;

            bin_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (srst) begin
                    st_d.addr = '0;
                end else if (adv) begin
                    st_d.addr = st_q.addr + AW'(1);
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            always_comb begin
                sel = '0;
                sel[st_q.addr] = 1'b1;
            end
        end else begin : g_ring
            typedef struct packed {
                logic [NPTS-1:0] ring;
            } ring_st_t;

            ring_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (srst) begin
                    st_d.ring = {{(NPTS-1){1'b0}}, 1'b1};
                end else if (adv) begin
                    st_d.ring = {st_q.ring[NPTS-2:0], st_q.ring[NPTS-1]};
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign sel = st_q.ring;
        end
    endgenerate
endmodule

// File: rtl/mon_tap_sel.sv
module mon_tap_sel #(
    parameter int NPTS = 8
) (
    input  logic            test_en,
    input  logic            func_out,
    input  logic [NPTS-1:0] mon_pts,
    input  logic [NPTS-1:0] sel,
    output logic            pin_out
);
    logic [NPTS-1:0] gated;
    logic            picked;

    genvar gi;
    generate
        for (gi = 0; gi < NPTS; gi++) begin : g_gate
            assign gated[gi] = mon_pts[gi] & sel[gi];
        end
    endgenerate

    always_comb begin
        picked  = |gated;
        pin_out = test_en ? picked : func_out;
    end
endmodule

// File: rtl/mon_tap.sv
module mon_tap
    import mon_tap_pkg::*;
#(
    parameter int         ADDR_W = 3,
    parameter sel_style_e STYLE  = SEL_BINARY
) (
    input  logic                   clk,
    input  logic                   srst,
    input  logic                   test_en,
    input  logic                   func_out,
    input  logic [(1<<ADDR_W)-1:0] mon_pts,
    output logic                   pin_out
);
    localparam int NPTS = 1 << ADDR_W;

    logic [NPTS-1:0] sel_w;

    mon_tap_ctr #(.NPTS(NPTS), .STYLE(STYLE)) u_ctr (
        .clk  (clk),
        .srst (srst),
        .adv  (test_en),
        .sel  (sel_w)
    );

    mon_tap_sel #(.NPTS(NPTS)) u_sel (
        .test_en  (test_en),
        .func_out (func_out),
        .mon_pts  (mon_pts),
        .sel      (sel_w),
        .pin_out  (pin_out)
    );
endmodule

// File: rtl/mon_tap_chk.sv
module mon_tap_chk #(
    parameter int NPTS = 8
) (
    input logic            clk,
    input logic            srst,
    input logic            test_en,
    input logic            func_out,
    input logic            pin_out,
    input logic [NPTS-1:0] sel
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (srst) armed_q <= 1'b1;
    end

    // R2
    rst_home_chk: assert property (@(posedge clk)
        srst |=> (sel == {{(NPTS-1){1'b0}}, 1'b1}));

    // R7
    one_sel_chk: assert property (@(posedge clk) disable iff (srst || !armed_q)
        $countones(sel) == 1);

    // R3
    step_rot_chk: assert property (@(posedge clk) disable iff (srst || !armed_q)
        test_en |=> (sel == {$past(sel[NPTS-2:0]), $past(sel[NPTS-1])}));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (srst || !armed_q)
        !test_en |=> $stable(sel));

    // R5
    func_pass_chk: assert property (@(posedge clk) disable iff (srst || !armed_q)
        !test_en |-> (pin_out == func_out));
endmodule

bind mon_tap mon_tap_chk #(.NPTS(NPTS)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .test_en  (test_en),
    .func_out (func_out),
    .pin_out  (pin_out),
    .sel      (sel_w)
);

// File: tb/sim_mon_tap.sv
`timescale 1ns/1ps
module sim_mon_tap;
    import mon_tap_pkg::*;

    localparam int AW = 3;
    localparam int N  = 1 << AW;

    logic         clk = 1'b0;
    logic         srst = 1'b0;
    logic         test_en = 1'b0;
    logic         func_out = 1'b0;
    logic [N-1:0] mon_pts = '0;
    logic         pin0, pin1;

    int checks = 0;
    int failures = 0;
    int idx = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    mon_tap #(.ADDR_W(AW), .STYLE(SEL_BINARY)) u0 (
        .clk(clk), .srst(srst), .test_en(test_en), .func_out(func_out),
        .mon_pts(mon_pts), .pin_out(pin0));

    mon_tap #(.ADDR_W(AW), .STYLE(SEL_RING)) u1 (
        .clk(clk), .srst(srst), .test_en(test_en), .func_out(func_out),
        .mon_pts(mon_pts), .pin_out(pin1));

    // Driver: applies inputs at the falling edge and queues the pin value
    // expected after the next rising edge.
    task automatic step(input logic rs, input logic te, input logic [N-1:0] mp,
                        input logic fo, input string tag);
        logic e;
        @(negedge clk);
        srst = rs; test_en = te; mon_pts = mp; func_out = fo;
        if (rs) idx = 0;
        else if (te) idx = (idx + 1) % N;
        e = te ? mp[idx] : fo;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pin0 !== e) begin
                    failures++;
                    $display("FAIL %s u0 pin_out actual=%b expected=%b", t, pin0, e);
                end
                checks++;
                if (pin1 !== e) begin
                    failures++;
                    $display("FAIL R9 (%s) u1 pin_out actual=%b expected=%b", t, pin1, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        pat = 8'b1011_0010;
        // R2: reset wins over test_en, point 0 selected
        step(1'b1, 1'b1, pat, 1'b1, "R2");
        // R1/R3/R4: walk the points through two wraps
        for (int k = 0; k < 2 * N + 1; k++) begin
            step(1'b0, 1'b1, pat, 1'b0, (k == N - 1) ? "R4" : "R3");
        end
        // R1: a different pattern under test
        pat = 8'b0110_1101;
        for (int k = 0; k < N; k++) step(1'b0, 1'b1, pat, 1'b1, "R1");
        // R5: normal mode shows func_out whatever mon_pts does
        step(1'b0, 1'b0, 8'hFF, 1'b0, "R5");
        step(1'b0, 1'b0, 8'h00, 1'b1, "R5");
        step(1'b0, 1'b0, 8'hA5, 1'b0, "R5");
        // R6: index held; test mode re-entry shows the next point in order
        step(1'b0, 1'b1, pat, 1'b0, "R6");
        // R8: toggle all unselected points each edge
        for (int k = 0; k < N; k++) begin
            logic [N-1:0] m;
            int nx;
            nx = (idx + 1) % N;
            m = (k % 2 == 0) ? ~pat : pat;
            m[nx] = pat[nx];
            step(1'b0, 1'b1, m, 1'b0, "R8");
        end
        // R2: mid-sequence reset, then a single-hot pattern
        step(1'b1, 1'b0, 8'b0000_0001, 1'b0, "R2");
        for (int k = 0; k < N; k++) step(1'b0, 1'b1, 8'b0000_0100, 1'b1, "R7");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule